// File: doc/BRIEF.md
# First-Error Capture and Status Unit

This unit collects protocol errors that upstream packet checkers have already decoded. Each error type arrives as a one-cycle strobe, together with the header fields of the offending packet and, when the packet has one, its data flit. The unit keeps a sticky status vector with one bit per error type. It drives an interrupt while any status bit is set.

The first error to arrive while the log is empty is recorded in a small set of log registers: its header fields, its data flit and its type code. Any later error that the log tracks sets an overrun flag. The recorded contents stay unchanged until software re-arms the log. One error type, the global clock drop, only updates its status bit and never touches the log.

Software reaches all state through a simple single-cycle register port. Writes take effect at the next clock edge. Reads are combinational and have no side effects.

Top module: `errlog_unit`

## Requirements
- R1: Strobe bit i sets status bit i at the next clock edge. Once set, a status bit stays set until software clears it. The bit order is: 0 request bad command, 1 reply bad command, 2 request short, 3 reply short, 4 request long, 5 reply long, 6 request bad data, 7 reply bad data, 8 request bad address, 9 request bad invalidate, 10 global clock drop.
- R2: Reading any address leaves the state unchanged. The status vector keeps its value through a reset.
- R3: `irq` is 1 exactly when at least one status bit is set.
- R4: A write to address 0 ORs `reg_wdata[10:0]` into the status vector. A write to address 1 clears the status bits that are 1 in `reg_wdata[10:0]` and leaves the other bits unchanged. If a strobe sets a bit in the same cycle that a clear targets it, the bit stays set.
- R5: When a strobe among bits 9:0 fires while valid is 0, the unit does all of the following: it stores the command, supplemental, source and address fields; it sets valid; it clears overrun; and it writes the index of the strobe into the type field. If several strobes fire in the same cycle, the lowest index is recorded. All status bits of that cycle are still set.
- R6: When a strobe among bits 9:0 fires while valid is 1, the unit sets overrun and leaves every recorded field unchanged.
- R7: A cycle whose only strobe is bit 10 changes only status bit 10. It leaves valid, overrun, type and every header log field unchanged.
- R8: Reads return the following. Address 2 is the header word: command in [6:0], supplemental in [18:8], source in [30:20], type in [35:32], overrun in [40] and valid in [44], with every other bit 0. Address 3 returns the logged address in [37:0], upper bits 0. Address 4 returns the data log. Address 0 returns the status in [10:0], upper bits 0. Addresses 1, 5, 6 and 7 read as 0.
- R9: The data log is loaded from `pkt_data` under the R5 condition, and only when `pkt_has_data` is 1. Otherwise the data log keeps its value.
- R10: A write to address 2 loads valid from bit 44 and overrun from bit 40. Writing 0 to bit 44 re-arms the log. The write is ignored in a cycle where a strobe among bits 9:0 fires.
- R11: While reset is asserted, valid, overrun, type and all log fields are set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (log only) |
| err_strobe | input | 11 | One-hot-per-type error strobes |
| pkt_cmd | input | 7 | Command field of offending packet |
| pkt_suppl | input | 11 | Supplemental field |
| pkt_src | input | 11 | Source field |
| pkt_addr | input | 38 | Address field |
| pkt_data | input | 64 | Data flit |
| pkt_has_data | input | 1 | Packet carries a data flit |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data |
| irq | output | 1 | Interrupt, any status bit set |

## Verification
The hardest situation to reach from the ports is a cycle in which several events collide. Examples are a mask-clear write landing on a bit that a strobe sets in that same cycle, a re-arm write that arrives together with a logged strobe, or a global clock drop that fires while the log is valid. Directed steps build each of these collisions explicitly. A seeded random phase then drives sparse multi-bit strobes mixed with writes to every address, including re-arms. A bench model checks every register after each cycle.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int NUM_ERR  = 11;
  localparam int CLK_IDX  = 10;            // global clock drop, not logged
  localparam int LOG_ERR  = NUM_ERR - 1;   // types that use the log
  localparam int CMD_W    = 7;
  localparam int SUP_W    = 11;
  localparam int SRC_W    = 11;
  localparam int ADR_W    = 38;
  localparam int DAT_W    = 64;
  localparam int TYP_W    = 4;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_CLEAR  = 3'd1,
    SEL_HDR    = 3'd2,
    SEL_ADDR   = 3'd3,
    SEL_DATA   = 3'd4
  } reg_sel_e;

  localparam int HDR_OVR_BIT = 40;
  localparam int HDR_VAL_BIT = 44;

  // lowest set index among logged strobes
  function automatic logic [TYP_W-1:0] first_err(input logic [LOG_ERR-1:0] v);
    logic [TYP_W-1:0] idx;
    idx = '0;
    for (int i = LOG_ERR - 1; i >= 0; i--)
      if (v[i]) idx = TYP_W'(i);
    return idx;
  endfunction

  function automatic logic [DAT_W-1:0] pack_hdr(
      input logic [CMD_W-1:0] cmd, input logic [SUP_W-1:0] sup,
      input logic [SRC_W-1:0] src, input logic [TYP_W-1:0] typ,
      input logic ovr, input logic val);
    logic [DAT_W-1:0] w;
    w = '0;
    w[CMD_W-1:0]   = cmd;
    w[8 +: SUP_W]  = sup;
    w[20 +: SRC_W] = src;
    w[32 +: TYP_W] = typ;
    w[HDR_OVR_BIT] = ovr;
    w[HDR_VAL_BIT] = val;
    return w;
  endfunction
endpackage

// File: rtl/errlog_status.sv
module errlog_status
  import errlog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] strobe,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_ERR-1:0] wbits,
  output logic [NUM_ERR-1:0] status
);
  logic [NUM_ERR-1:0] clr_mask, set_mask;

  assign clr_mask = clr_we ? wbits : '0;
  assign set_mask = set_we ? wbits : '0;

  // no reset: contents survive reset by design
  always_ff @(posedge clk)
    status <= (status & ~clr_mask) | set_mask | strobe;

  // R1
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |=> ((status & $past(strobe)) == $past(strobe)));

  // R4
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we && ((strobe & wbits) == '0))
      |=> ((status & $past(wbits)) == '0));
endmodule

// File: rtl/errlog_record.sv
module errlog_record
  import errlog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOG_ERR-1:0] strobe,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [SUP_W-1:0]   sup,
  input  logic [SRC_W-1:0]   src,
  input  logic [ADR_W-1:0]   adr,
  input  logic [DAT_W-1:0]   dat,
  input  logic               has_dat,
  input  logic               sw_we,
  input  logic               sw_val,
  input  logic               sw_ovr,
  output logic               valid,
  output logic               ovr,
  output logic [TYP_W-1:0]   typ,
  output logic [CMD_W-1:0]   cmd_q,
  output logic [SUP_W-1:0]   sup_q,
  output logic [SRC_W-1:0]   src_q,
  output logic [ADR_W-1:0]   adr_q,
  output logic [DAT_W-1:0]   dat_q
);
  logic hit, capture, overrun_ev;

  assign hit        = |strobe;
  assign capture    = hit && !valid;
  assign overrun_ev = hit && valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      ovr   <= 1'b0;
      typ   <= '0;
      cmd_q <= '0;
      sup_q <= '0;
      src_q <= '0;
      adr_q <= '0;
      dat_q <= '0;
    end else if (capture) begin
      valid <= 1'b1;
      ovr   <= 1'b0;
      typ   <= first_err(strobe);
      cmd_q <= cmd;
      sup_q <= sup;
      src_q <= src;
      adr_q <= adr;
      if (has_dat) dat_q <= dat;
    end else if (overrun_ev) begin
      ovr <= 1'b1;
    end else if (sw_we) begin
      valid <= sw_val;
      ovr   <= sw_ovr;
    end
  end

  // R5
  first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (valid && !ovr && typ == first_err($past(strobe))
                 && cmd_q == $past(cmd) && adr_q == $past(adr)));

  // R6
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> (ovr && valid && $stable(typ) && $stable(cmd_q)
                    && $stable(adr_q) && $stable(dat_q)));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && has_dat) |=> $stable(dat_q));
endmodule

// File: rtl/errlog_unit.sv
module errlog_unit
  import errlog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] err_strobe,
  input  logic [CMD_W-1:0]   pkt_cmd,
  input  logic [SUP_W-1:0]   pkt_suppl,
  input  logic [SRC_W-1:0]   pkt_src,
  input  logic [ADR_W-1:0]   pkt_addr,
  input  logic [DAT_W-1:0]   pkt_data,
  input  logic               pkt_has_data,
  input  logic               reg_wr,
  input  logic [SEL_W-1:0]   reg_addr,
  input  logic [DAT_W-1:0]   reg_wdata,
  output logic [DAT_W-1:0]   reg_rdata,
  output logic               irq
);
  logic [NUM_ERR-1:0] status;
  logic               set_we, clr_we, hdr_we;
  logic               log_valid, log_ovr;
  logic [TYP_W-1:0]   log_typ;
  logic [CMD_W-1:0]   log_cmd;
  logic [SUP_W-1:0]   log_sup;
  logic [SRC_W-1:0]   log_src;
  logic [ADR_W-1:0]   log_adr;
  logic [DAT_W-1:0]   log_dat;
  logic [DAT_W-1:0]   hdr_word;
  logic               clk_drop_only;

  assign set_we = reg_wr && (reg_addr == SEL_STATUS);
  assign clr_we = reg_wr && (reg_addr == SEL_CLEAR);
  assign hdr_we = reg_wr && (reg_addr == SEL_HDR);
  assign clk_drop_only = (err_strobe == (NUM_ERR'(1) << CLK_IDX));

  errlog_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (err_strobe),
    .set_we (set_we),
    .clr_we (clr_we),
    .wbits  (reg_wdata[NUM_ERR-1:0]),
    .status (status)
  );

  errlog_record u_record (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (err_strobe[LOG_ERR-1:0]),
    .cmd     (pkt_cmd),
    .sup     (pkt_suppl),
    .src     (pkt_src),
    .adr     (pkt_addr),
    .dat     (pkt_data),
    .has_dat (pkt_has_data),
    .sw_we   (hdr_we),
    .sw_val  (reg_wdata[HDR_VAL_BIT]),
    .sw_ovr  (reg_wdata[HDR_OVR_BIT]),
    .valid   (log_valid),
    .ovr     (log_ovr),
    .typ     (log_typ),
    .cmd_q   (log_cmd),
    .sup_q   (log_sup),
    .src_q   (log_src),
    .adr_q   (log_adr),
    .dat_q   (log_dat)
  );

  assign hdr_word = pack_hdr(log_cmd, log_sup, log_src, log_typ, log_ovr, log_valid);
  assign irq      = |status;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_STATUS: reg_rdata[NUM_ERR-1:0] = status;
      SEL_HDR:    reg_rdata = hdr_word;
      SEL_ADDR:   reg_rdata[ADR_W-1:0] = log_adr;
      SEL_DATA:   reg_rdata = log_dat;
      default:    reg_rdata = '0;
    endcase
  end

  // R3
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_strobe) |=> irq);

  // R7
  clk_drop_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_drop_only && !hdr_we) |=> ($stable(hdr_word) && $stable(log_adr) && irq));
endmodule

// File: tb/errlog_unit_test.sv
`timescale 1ns/1ps
module errlog_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] err_strobe = '0;
  logic [6:0]  pkt_cmd = '0;
  logic [10:0] pkt_suppl = '0;
  logic [10:0] pkt_src = '0;
  logic [37:0] pkt_addr = '0;
  logic [63:0] pkt_data = '0;
  logic        pkt_has_data = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  // model state
  logic [10:0] m_st;
  logic        m_val, m_ovr;
  logic [3:0]  m_typ;
  logic [6:0]  m_cmd;
  logic [10:0] m_sup, m_src;
  logic [37:0] m_adr;
  logic [63:0] m_dat;

  always #2 clk = ~clk;   // 250 MHz

  errlog_unit uut (.*);

  function automatic logic [63:0] exp_read(int a);
    logic [63:0] w;
    w = 64'd0;
    case (a)
      0: w = {53'd0, m_st};
      2: begin
           w = {19'd0, m_val, 3'd0, m_ovr, 4'd0, m_typ, 1'b0, m_src, 1'b0, m_sup, 1'b0, m_cmd};
         end
      3: w = {26'd0, m_adr};
      4: w = m_dat;
      default: w = 64'd0;
    endcase
    return w;
  endfunction

  function automatic logic [3:0] lowest(logic [9:0] v);
    for (int i = 0; i < 10; i++) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic compare(string req, logic [63:0] act, logic [63:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic verify(string req);
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a);
      #0.1;
      compare(req, reg_rdata, exp_read(a));
    end
    compare({req, " R3 irq"}, {63'd0, irq}, {63'd0, |m_st});
  endtask

  task automatic model_edge();
    logic [10:0] clr, setm;
    clr  = (reg_wr && reg_addr == 3'd1) ? reg_wdata[10:0] : 11'd0;
    setm = (reg_wr && reg_addr == 3'd0) ? reg_wdata[10:0] : 11'd0;
    m_st = (m_st & ~clr) | setm | err_strobe;
    if (err_strobe[9:0] != 0) begin
      if (!m_val) begin
        m_val = 1'b1; m_ovr = 1'b0; m_typ = lowest(err_strobe[9:0]);
        m_cmd = pkt_cmd; m_sup = pkt_suppl; m_src = pkt_src; m_adr = pkt_addr;
        if (pkt_has_data) m_dat = pkt_data;
      end else m_ovr = 1'b1;
    end else if (reg_wr && reg_addr == 3'd2) begin
      m_val = reg_wdata[44]; m_ovr = reg_wdata[40];
    end
  endtask

  // drive one cycle: inputs already set by caller
  task automatic cycle(string req);
    model_edge();
    @(posedge clk);
    #1;
    err_strobe = '0; reg_wr = 1'b0; pkt_has_data = 1'b0;
    verify(req);
  endtask

  task automatic rand_pkt();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    pkt_addr  = t[37:0];
    pkt_cmd   = t[44:38];
    pkt_suppl = t[55:45];
    t = {$urandom(), $urandom()};
    pkt_src   = t[10:0];
    pkt_data  = {$urandom(), $urandom()};
    pkt_has_data = t[20];
  endtask

  task automatic do_reset(string req);
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
    m_val = 0; m_ovr = 0; m_typ = 0; m_cmd = 0; m_sup = 0; m_src = 0; m_adr = 0; m_dat = 0;
    verify(req);
  endtask

  task automatic wr(logic [2:0] a, logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_st = 0;
    @(posedge clk); #1;
    // clear unknown status before reset release (status is not reset)
    wr(3'd1, 64'h7FF);
    @(posedge clk); #1; reg_wr = 1'b0;
    do_reset("R11 reset state");

    // R1 single strobe, R5 capture with data, R9
    rand_pkt(); pkt_has_data = 1'b1; err_strobe = 11'h020;
    cycle("R5 R9 first capture type 5");
    // R6 overrun
    rand_pkt(); err_strobe = 11'h001;
    cycle("R6 overrun keeps log");
    // R7 clock drop only while valid
    rand_pkt(); err_strobe = 11'h400;
    cycle("R7 clock drop bypass");
    // R10 re-arm
    wr(3'd2, 64'd0);
    cycle("R10 re-arm");
    // R7 clock drop while empty
    rand_pkt(); err_strobe = 11'h400;
    cycle("R7 clock drop leaves log empty");
    // R5 multi-strobe lowest wins; R9 no data keeps data log
    rand_pkt(); pkt_has_data = 1'b0; err_strobe = 11'h348;
    cycle("R5 R9 lowest index logged");
    // R10 write ignored with logged strobe
    wr(3'd2, 64'd0); rand_pkt(); err_strobe = 11'h002;
    cycle("R10 write ignored on strobe");
    // R4 clear with same-bit error
    wr(3'd1, 64'h7FF); err_strobe = 11'h008;
    cycle("R4 error beats clear");
    // R4 status write sets bits
    wr(3'd0, 64'h0A0);
    cycle("R4 software set");
    // R2 survive reset
    do_reset("R2 status survives reset");
    wr(3'd1, 64'h7FF);
    cycle("R3 irq low after full clear");
    // R8 header layout with all-ones fields
    pkt_cmd = '1; pkt_suppl = '1; pkt_src = '1; pkt_addr = '1; pkt_data = '1;
    pkt_has_data = 1'b1; err_strobe = 11'h200;
    cycle("R8 header layout");

    for (int k = 0; k < 3000; k++) begin
      rand_pkt();
      if ($urandom_range(3) == 0) err_strobe = 11'($urandom()) & 11'($urandom()) & 11'($urandom());
      if ($urandom_range(3) == 0) begin
        case ($urandom_range(3))
          0: wr(3'd0, 64'(1) << $urandom_range(10));
          1: wr(3'd1, {$urandom(), $urandom()});
          2: wr(3'd2, 64'd0);
          default: wr(3'($urandom_range(7)), {$urandom(), $urandom()});
        endcase
      end
      cycle("R1 R4 R5 R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule